// File: doc/BRIEF.md
# Baud-framed serial control word receiver

This block takes a 16-bit control word that a signal processor shifts in once per symbol period on one data line. It decodes the word into a signed four-level line symbol and a set of receive and transmit configuration outputs. Everything runs on a continuous oversampling clock that has 48 cycles per symbol period. A separate, slower baud clock is sampled in that domain. Its rising edge marks the first bit slot of every frame.

The word arrives MSB first in the first 16 slots of the frame. The other 32 slots carry nothing of value. When bit 0 has been sampled, the decoded symbol, a one-cycle valid strobe and all configuration fields are registered together. Between strobes the outputs hold, so downstream logic never sees a partly shifted word. Receive gain codes outside the defined set raise a flag and leave the last good gain in place.

Top module: `ctrl_word_rx`

## Requirements
- R1: The first clock edge that sees `baud_i` high after it was sampled low is slot 1. Slots then advance by one per clock and wrap from 48 back to 1. From reset until the first such edge, nothing is captured and no strobe is issued.
- R2: `sdata_i` is sampled in slots 1 to 16 as word bits 15 down to 0. Values in slots 17 to 48 have no effect on any output.
- R3: `sym_vld_o` is high for exactly one cycle, the cycle after the edge that sampled slot 16, and is low otherwise.
- R4: Word bit 15 is the transmit enable and appears on `tx_en_o`. When it is 0, `sym_o` is 0 whatever bits 14:13 hold.
- R5: When bit 15 is 1, bits 14:13 select `sym_o`, a 3-bit two's complement level: 00 gives -3, 01 gives -1, 11 gives +1 and 10 gives +3.
- R6: Bits 12:10 give the receive gain code. Codes 0 to 4 (0, 3, 6, 9 and 12 dB) are copied to `gain_o`.
- R7: Codes 5 to 7 set `gain_rsvd_o` and leave `gain_o` at its previous value. A valid code clears `gain_rsvd_o`.
- R8: Bit 9 drives `loopback_o`, and bit 8 drives `boost_o` (high means +0.5 dB). Bits 7:0 have no effect.
- R9: `sym_o`, `tx_en_o`, `gain_o`, `gain_rsvd_o`, `loopback_o` and `boost_o` change only in the cycle in which `sym_vld_o` is high.
- R10: While `rst_ni` is low, all outputs are 0 and the receiver returns to the unaligned state.
- R11: A baud rising edge in the middle of a frame restarts the count at slot 1. The partly received word is dropped without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 48x oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| baud_i | input | 1 | Baud framing clock; a rising edge marks slot 1 |
| sdata_i | input | 1 | Serial control data, MSB first |
| sym_o | output | 3 | Signed symbol level (-3, -1, 0, +1, +3) |
| sym_vld_o | output | 1 | One-cycle strobe when a new word has been decoded |
| tx_en_o | output | 1 | Transmit enable from the last word |
| gain_o | output | 3 | Last valid receive gain code |
| gain_rsvd_o | output | 1 | Last word carried a reserved gain code |
| loopback_o | output | 1 | Loopback enable |
| boost_o | output | 1 | Transmit power boost |

## Verification
The bench sends complete frames that sweep all four symbol codes with the enable set. It also sends frames with the enable cleared, which separates a correct zero symbol from a symbol read straight from bits 14:13. It steps through every gain code, including a run of reserved codes followed by a valid one, which shows both that the gain is held and that the flag clears. The same upper byte is sent with different low bytes, and random data fills the idle slots, so any leak from ignored bits shows up. Noise sent before the first baud edge and a frame cut short by an early baud edge check alignment and the dropping of a partial word. A reset in the middle of the run checks recovery.

// File: rtl/ctrl_word_pkg.sv
package ctrl_word_pkg;
  localparam int WORD_W      = 16;
  localparam int FRAME_SLOTS = 48;
  localparam int GAIN_W      = 3;
  localparam int GAIN_MAX    = 4;

  typedef logic signed [2:0] sym_t;

  // Gray-style four-level map
  function automatic sym_t map_sym(input logic [1:0] code);
    case (code)
      2'b00:   return -3'sd3;
      2'b01:   return -3'sd1;
      2'b11:   return  3'sd1;
      default: return  3'sd3;
    endcase
  endfunction
endpackage

// File: rtl/cw_slot_cnt.sv
module cw_slot_cnt #(
  parameter int FRAME_SLOTS = ctrl_word_pkg::FRAME_SLOTS,
  parameter int WORD_W      = ctrl_word_pkg::WORD_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic baud_i,
  output logic shift_o,
  output logic last_o
);
  localparam int CW = $clog2(FRAME_SLOTS + 1);

  logic          baud_q;
  logic          rise;
  logic [CW-1:0] cnt_q, slot_d;

  assign rise = baud_i & ~baud_q;

  // 0 means unaligned; slots run 1..FRAME_SLOTS
  always_comb begin
    if (rise)                               slot_d = CW'(1);
    else if (cnt_q == '0)                   slot_d = '0;
    else if (cnt_q == CW'(FRAME_SLOTS))     slot_d = CW'(1);
    else                                    slot_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      baud_q <= baud_i;
      cnt_q  <= slot_d;
    end
  end

  assign shift_o = (slot_d != '0) && (slot_d <= CW'(WORD_W));
  assign last_o  = (slot_d == CW'(WORD_W));
endmodule

// File: rtl/cw_shift.sv
module cw_shift #(
  parameter int WORD_W = ctrl_word_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[WORD_W-3:0], sdata_i};
  end

  // LSB bypass so the word is complete in the slot that samples it
  assign word_o = {sh_q, sdata_i};
endmodule

// File: rtl/cw_decode.sv
module cw_decode
  import ctrl_word_pkg::*;
#(
  parameter int WORD_W = ctrl_word_pkg::WORD_W,
  parameter int GAIN_W = ctrl_word_pkg::GAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output sym_t              sym_o,
  output logic              sym_vld_o,
  output logic              tx_en_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              gain_rsvd_o,
  output logic              loopback_o,
  output logic              boost_o
);
  localparam int EN_BIT  = WORD_W - 1;
  localparam int SYM_HI  = WORD_W - 2;
  localparam int GAIN_HI = WORD_W - 4;
  localparam int GAIN_LO = GAIN_HI - GAIN_W + 1;
  localparam int LB_BIT  = GAIN_LO - 1;
  localparam int BST_BIT = GAIN_LO - 2;

  logic [GAIN_W-1:0] gain_code;
  logic              gain_bad;

  assign gain_code = word_i[GAIN_HI:GAIN_LO];
  assign gain_bad  = gain_code > GAIN_W'(GAIN_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o       <= '0;
      sym_vld_o   <= 1'b0;
      tx_en_o     <= 1'b0;
      gain_o      <= '0;
      gain_rsvd_o <= 1'b0;
      loopback_o  <= 1'b0;
      boost_o     <= 1'b0;
    end else begin
      sym_vld_o <= load_i;
      if (load_i) begin
        tx_en_o     <= word_i[EN_BIT];
        sym_o       <= word_i[EN_BIT] ? map_sym(word_i[SYM_HI -: 2]) : '0;
        gain_rsvd_o <= gain_bad;
        if (!gain_bad) gain_o <= gain_code;
        loopback_o  <= word_i[LB_BIT];
        boost_o     <= word_i[BST_BIT];
      end
    end
  end
endmodule

// File: rtl/ctrl_word_rx.sv
module ctrl_word_rx
  import ctrl_word_pkg::*;
#(
  parameter int FRAME_SLOTS = ctrl_word_pkg::FRAME_SLOTS,
  parameter int WORD_W      = ctrl_word_pkg::WORD_W,
  parameter int GAIN_W      = ctrl_word_pkg::GAIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_i,
  input  logic              sdata_i,
  output logic signed [2:0] sym_o,
  output logic              sym_vld_o,
  output logic              tx_en_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              gain_rsvd_o,
  output logic              loopback_o,
  output logic              boost_o
);
  logic              shift, last;
  logic [WORD_W-1:0] word;

  cw_slot_cnt #(.FRAME_SLOTS(FRAME_SLOTS), .WORD_W(WORD_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .baud_i  (baud_i),
    .shift_o (shift),
    .last_o  (last)
  );

  cw_shift #(.WORD_W(WORD_W)) i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .sdata_i (sdata_i),
    .word_o  (word)
  );

  cw_decode #(.WORD_W(WORD_W), .GAIN_W(GAIN_W)) i_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (last),
    .word_i      (word),
    .sym_o       (sym_o),
    .sym_vld_o   (sym_vld_o),
    .tx_en_o     (tx_en_o),
    .gain_o      (gain_o),
    .gain_rsvd_o (gain_rsvd_o),
    .loopback_o  (loopback_o),
    .boost_o     (boost_o)
  );
endmodule

// File: rtl/ctrl_word_rx_chk.sv
module ctrl_word_rx_chk #(
  parameter int GAIN_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic signed [2:0] sym_o,
  input logic              sym_vld_o,
  input logic              tx_en_o,
  input logic [GAIN_W-1:0] gain_o,
  input logic              gain_rsvd_o,
  input logic              loopback_o,
  input logic              boost_o
);
  // R3
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_vld_o |=> !sym_vld_o);

  // R4
  zero_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> sym_o == 3'sd0);

  // R5
  odd_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> (sym_o[0] && sym_o != -3'sd4));

  // R6
  gain_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gain_o <= GAIN_W'(4));

  // R9
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_vld_o |-> ($stable(sym_o) && $stable(tx_en_o) && $stable(gain_o) &&
                    $stable(gain_rsvd_o) && $stable(loopback_o) && $stable(boost_o)));
endmodule

bind ctrl_word_rx ctrl_word_rx_chk #(.GAIN_W(GAIN_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sym_o       (sym_o),
  .sym_vld_o   (sym_vld_o),
  .tx_en_o     (tx_en_o),
  .gain_o      (gain_o),
  .gain_rsvd_o (gain_rsvd_o),
  .loopback_o  (loopback_o),
  .boost_o     (boost_o)
);

// File: tb/test_ctrl_word_rx.sv
`timescale 1ns/1ps
module test_ctrl_word_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud = 1'b0;
  logic sdata = 1'b0;
  logic signed [2:0] sym;
  logic sym_vld, tx_en, gain_rsvd, lb, boost;
  logic [2:0] gain;

  int checks = 0, errors = 0, cyc = 0, strobes = 0;

  always #5 clk = ~clk;

  ctrl_word_rx i_ctrl_word_rx (
    .clk_i(clk), .rst_ni(rst_n), .baud_i(baud), .sdata_i(sdata),
    .sym_o(sym), .sym_vld_o(sym_vld), .tx_en_o(tx_en), .gain_o(gain),
    .gain_rsvd_o(gain_rsvd), .loopback_o(lb), .boost_o(boost)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_slot = 0, m_sym = 0, m_gain = 0;
  bit m_prev = 1'b1, m_vld = 0, m_en = 0, m_rsvd = 0, m_lb = 0, m_bst = 0;
  bit m_bits[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_slot = 0; m_prev = 1'b1; m_vld = 0; m_sym = 0; m_en = 0;
      m_gain = 0; m_rsvd = 0; m_lb = 0; m_bst = 0; m_bits.delete();
    end else begin
      if (baud && !m_prev) m_slot = 1;
      else if (m_slot != 0) m_slot = (m_slot == 48) ? 1 : m_slot + 1;
      m_prev = baud;
      m_vld = 0;
      if (m_slot == 1) m_bits.delete();
      if (m_slot >= 1 && m_slot <= 16) m_bits.push_back(sdata);
      if (m_slot == 16) begin
        int code;
        m_vld = 1;
        m_en = m_bits[0];
        code = 2 * m_bits[1] + m_bits[2];
        if (!m_en) m_sym = 0;
        else case (code)
          0: m_sym = -3;
          1: m_sym = -1;
          3: m_sym = 1;
          default: m_sym = 3;
        endcase
        code = 4 * m_bits[3] + 2 * m_bits[4] + m_bits[5];
        if (code > 4) m_rsvd = 1;
        else begin m_rsvd = 0; m_gain = code; end
        m_lb = m_bits[6];
        m_bst = m_bits[7];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (sym_vld) strobes++;
      chk("R3 strobe", int'(sym_vld), int'(m_vld));
      chk("R5 symbol", int'(sym), m_sym);
      chk("R4 enable", int'(tx_en), int'(m_en));
      chk("R6 gain", int'(gain), m_gain);
      chk("R7 reserved flag", int'(gain_rsvd), int'(m_rsvd));
      chk("R8 loopback", int'(lb), int'(m_lb));
      chk("R8 boost", int'(boost), int'(m_bst));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      errors++;
      $display("FAIL R3 watchdog actual=%0d expected<%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  // slots: number of slots driven (48 = full frame)
  task automatic send(input logic [15:0] w, input int slots);
    for (int s = 1; s <= slots; s++) begin
      step();
      baud  = (s <= slots / 2);
      sdata = (s <= 16) ? w[16 - s] : 1'($urandom);
    end
    step();
    baud = 1'b0;
  endtask

  initial begin
    int n0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    chk("R10 sym", int'(sym), 0);
    chk("R10 vld", int'(sym_vld), 0);
    chk("R10 en", int'(tx_en), 0);
    chk("R10 gain", int'(gain), 0);
    chk("R10 flags", int'({gain_rsvd, lb, boost}), 0);

    // R1 no capture before first baud edge
    for (int i = 0; i < 40; i++) begin step(); sdata = 1'($urandom); end
    chk("R1 unaligned strobes", strobes, 0);

    // R5 each symbol with enable
    send(16'b1_00_000_0_0_00000000, 48); chk("R5 -3", int'(sym), -3);
    send(16'b1_01_001_0_0_00000000, 48); chk("R5 -1", int'(sym), -1);
    send(16'b1_11_010_0_0_00000000, 48); chk("R5 +1", int'(sym), 1);
    send(16'b1_10_011_0_0_00000000, 48); chk("R5 +3", int'(sym), 3);
    chk("R6 gain 3", int'(gain), 3);
    // R4 enable off
    send(16'b0_10_100_0_0_00000000, 48);
    chk("R4 forced zero", int'(sym), 0);
    chk("R6 gain 4", int'(gain), 4);
    // R7 reserved codes hold gain
    send(16'b1_11_101_0_0_00000000, 48);
    chk("R7 hold", int'(gain), 4); chk("R7 flag", int'(gain_rsvd), 1);
    send(16'b1_11_111_1_0_00000000, 48);
    chk("R7 hold 7", int'(gain), 4);
    send(16'b1_11_001_1_1_00000000, 48);
    chk("R7 cleared", int'(gain_rsvd), 0); chk("R6 gain 1", int'(gain), 1);
    chk("R8 loopback", int'(lb), 1); chk("R8 boost", int'(boost), 1);
    // R2 R8 low byte and idle slots ignored
    send(16'b1_00_010_0_1_11111111, 48);
    chk("R8 low byte", int'({sym, gain, lb, boost}), int'({3'b101, 3'd2, 1'b0, 1'b1}));
    send(16'b1_00_010_0_1_10100101, 48);
    chk("R2 low byte", int'({sym, gain, lb, boost}), int'({3'b101, 3'd2, 1'b0, 1'b1}));

    // R11 partial frame dropped on early baud edge
    n0 = strobes;
    send(16'b0_00_000_1_0_00000000, 10);
    chk("R11 no strobe", strobes, n0);
    chk("R11 kept", int'(sym), -3);
    send(16'b1_10_000_0_0_00000000, 48);
    chk("R11 realigned", int'(sym), 3);
    chk("R11 strobe count", strobes, n0 + 1);

    // R10 mid-run reset and recovery
    step(); rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R10 post sym", int'(sym), 0);
    chk("R10 post gain", int'(gain), 0);
    send(16'b1_01_011_1_0_00000000, 48);
    chk("R1 after reset", int'(sym), -1);

    for (int k = 0; k < 20; k++) send(16'($urandom), 48);
    repeat (4) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule